// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is the circular result queue of an out-of-order core. The issue stage claims one slot per cycle, in program order, and receives the slot number as the tag that its functional unit later places on the common result bus. Results, and separately computed store addresses, land in their slots in any order. Each cycle, the queue retires the unbroken run of finished slots that starts at the oldest one, up to a fixed number of lanes. Every lane carries either a register-file write or a memory write.

Branches also take a slot. The result bus reports whether a branch went the wrong way. When such a branch retires, everything issued after it is discarded before it can change architectural state, and the queue is empty again. A stores holds its address and its data in its slot, and the memory write leaves the queue only when the store retires with both fields present.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `rf_we`, `mem_we` and `flush` are all 0.
- R2: Each cycle with `alloc_valid` and `alloc_ready` both high claims one slot. Before the edge, `alloc_tag` gives that slot's index, and successive claims take indices that rise by one modulo DEPTH.
- R3: A slot never retires while any older slot is still unretired. A stalled oldest slot blocks every younger one.
- R4: Each cycle, up to CW consecutive finished slots retire, counted from the oldest, with lane 0 taking the oldest. Retirement shows on the outputs in the cycle after the edge that delivered the last missing field.
- R5: With DEPTH slots occupied, `alloc_ready` is 0, and a request made then claims nothing.
- R6: A store (kind 1) writes memory through its lane's `mem_we`, `mem_addr` and `mem_data` only when it retires, and only once both its address (`sta_*`) and its data (`res_*`) have arrived, in either order. A store never writes the register file.
- R7: Kind is encoded as 0 for a register-writing operation, 1 for a store and 2 for a branch. A kind-0 slot retires as `rf_we` with the destination and result of that slot.
- R8: A branch (kind 2) retires with no write. If it retired with `res_mispred` set, `flush` is 1 in that cycle, no younger slot ever writes, and the queue becomes empty with the next tag equal to the branch index plus 1.
- R9: A result or store address tagged for an unoccupied slot is ignored.
- R10: A newly claimed slot starts with no result, even if a result arrived for its index before the claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Issue stage requests a slot |
| alloc_kind | input | 2 | 0 register op, 1 store, 2 branch |
| alloc_dest | input | RW | Destination register index |
| alloc_ready | output | 1 | A slot can be claimed this cycle |
| alloc_tag | output | log2(DEPTH) | Index of the slot the next claim receives |
| res_valid | input | 1 | Result bus carries a value |
| res_tag | input | log2(DEPTH) | Slot the result belongs to |
| res_data | input | DW | Result value, or store data |
| res_mispred | input | 1 | Branch outcome was mispredicted |
| sta_valid | input | 1 | Store address is delivered |
| sta_tag | input | log2(DEPTH) | Slot of the store |
| sta_addr | input | AW | Store address |
| rf_we | output | CW | Per-lane register write enable |
| rf_idx | output | CW*RW | Per-lane destination register |
| rf_data | output | CW*DW | Per-lane register value |
| mem_we | output | CW | Per-lane memory write enable |
| mem_addr | output | CW*AW | Per-lane store address |
| mem_data | output | CW*DW | Per-lane store data |
| flush | output | 1 | A mispredicted branch retires this cycle |

## Verification
The bench returns results youngest first. A queue that retires finished slots without waiting for the oldest would write them out of order and be caught at once. It fills every slot so the indices wrap, then makes one more request, which a queue with broken full detection would accept and later retire as an extra write. It lets the slots behind a mispredicted branch finish before the branch, and places the older slot and the branch in the same retire cycle, which exposes a lane cut made at the wrong place. A result sent to a squashed index just before that index is claimed again checks that stale ready flags are cleared. Stores receive their two fields in both orders, so a design that writes memory on either field alone fails.

// File: rtl/rq_pkg.sv
// Package: shared encodings for the retire queue.
// Assumes: the slot kind arrives as a 2-bit code from the issue stage.
package rq_pkg;
    typedef enum logic [1:0] {
        RQ_ALU    = 2'd0,
        RQ_STORE  = 2'd1,
        RQ_BRANCH = 2'd2
    } rq_kind_e;
endpackage

// File: rtl/rq_ptrs.sv
// Module: oldest and next-free pointers of the circular queue, each with one
// extra wrap bit so that full and empty can be told apart.
// Assumes: DEPTH is a power of two; pop_n never exceeds the occupancy; the
// caller suppresses push while full or flushing.
module rq_ptrs #(
    parameter int DEPTH = 8,
    parameter int CW    = 2,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1,
    localparam int NW   = $clog2(CW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [NW-1:0] pop_n,
    input  logic          flush,
    output logic [IW-1:0] head_idx,
    output logic [IW-1:0] tail_idx,
    output logic [PW-1:0] occ,
    output logic          full,
    output logic          empty
);
    logic [PW-1:0] head_q, tail_q;
    logic [PW-1:0] head_nx;

    // Oldest pointer after this cycle's retirement.
    assign head_nx = head_q + PW'(pop_n);

    // Advance pointers; a flush snaps next-free onto the new oldest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_nx;
            if (flush)
                tail_q <= head_nx;
            else if (push)
                tail_q <= tail_q + PW'(1);
        end
    end

    // Derived occupancy flags.
    always_comb begin
        head_idx = head_q[IW-1:0];
        tail_idx = tail_q[IW-1:0];
        occ      = tail_q - head_q;
        empty    = (head_q == tail_q);
        full     = (head_q[IW-1:0] == tail_q[IW-1:0]) && (head_q[IW] != tail_q[IW]);
    end

    // R5
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH));

    // R3
    pop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        PW'(pop_n) <= occ);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/rq_commit_sel.sv
// Module: picks the run of slots that retire this cycle, starting at the
// oldest, stopping at the first unfinished slot, at CW lanes, or just after
// a mispredicted branch.
// Assumes: done_v and misp_v are only set for occupied slots.
module rq_commit_sel #(
    parameter int DEPTH = 8,
    parameter int CW    = 2,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1,
    localparam int NW   = $clog2(CW + 1)
) (
    input  logic [IW-1:0]          head_idx,
    input  logic [PW-1:0]          occ,
    input  logic [DEPTH-1:0]       done_v,
    input  logic [DEPTH-1:0]       misp_v,
    output logic [CW-1:0][IW-1:0]  lane_idx,
    output logic [CW-1:0]          lane_go,
    output logic [NW-1:0]          n_go,
    output logic                   flush
);
    logic alive;

    // Slot index seen by each lane, wrapping modulo DEPTH.
    for (genvar i = 0; i < CW; i++) begin : g_idx
        assign lane_idx[i] = head_idx + IW'(i);
    end

    // Walk the lanes oldest first; any gap or a mispredicted branch ends the run.
    always_comb begin
        alive   = 1'b1;
        lane_go = '0;
        n_go    = '0;
        flush   = 1'b0;
        for (int i = 0; i < CW; i++) begin
            if (alive && (PW'(i) < occ) && done_v[lane_idx[i]]) begin
                lane_go[i] = 1'b1;
                n_go       = n_go + NW'(1);
                if (misp_v[lane_idx[i]]) begin
                    flush = 1'b1;
                    alive = 1'b0;
                end
            end else begin
                alive = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rq_slots.sv
// Module: slot storage. Holds kind, destination, result, store address and
// their ready flags, plus the branch misprediction mark, for every slot.
// Assumes: a claim never targets a slot that retires in the same cycle;
// a flush leaves no occupied slot, so it clears every slot.
module rq_slots
    import rq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 2,
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int RW    = 5,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_we,
    input  logic [IW-1:0]         alloc_idx,
    input  rq_kind_e              alloc_kind,
    input  logic [RW-1:0]         alloc_dest,
    input  logic                  res_valid,
    input  logic [IW-1:0]         res_idx,
    input  logic [DW-1:0]         res_data,
    input  logic                  res_misp,
    input  logic                  sta_valid,
    input  logic [IW-1:0]         sta_idx,
    input  logic [AW-1:0]         sta_addr,
    input  logic                  flush,
    input  logic [CW-1:0]         lane_go,
    input  logic [CW-1:0][IW-1:0] lane_idx,
    output logic [DEPTH-1:0]      done_v,
    output logic [DEPTH-1:0]      misp_v,
    output logic [CW-1:0][1:0]    rd_kind,
    output logic [CW-1:0][RW-1:0] rd_dest,
    output logic [CW-1:0][DW-1:0] rd_data,
    output logic [CW-1:0][AW-1:0] rd_addr
);
    logic [DEPTH-1:0] busy_q, dok_q, aok_q, misp_q;
    rq_kind_e         kind_q [DEPTH];
    logic [RW-1:0]    dest_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DEPTH-1:0] clr_hit;

    // Mark the slots retiring this cycle.
    always_comb begin
        clr_hit = '0;
        for (int i = 0; i < CW; i++)
            if (lane_go[i]) clr_hit[lane_idx[i]] = 1'b1;
    end

    // Per-slot state: claim, retire, flush and field arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                busy_q[e] <= 1'b0;
                dok_q[e]  <= 1'b0;
                aok_q[e]  <= 1'b0;
                misp_q[e] <= 1'b0;
                kind_q[e] <= RQ_ALU;
                dest_q[e] <= '0;
                data_q[e] <= '0;
                addr_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (flush) begin
                    busy_q[e] <= 1'b0;
                    dok_q[e]  <= 1'b0;
                    aok_q[e]  <= 1'b0;
                end else if (alloc_we && alloc_idx == IW'(e)) begin
                    busy_q[e] <= 1'b1;
                    kind_q[e] <= alloc_kind;
                    dest_q[e] <= alloc_dest;
                    dok_q[e]  <= 1'b0;
                    aok_q[e]  <= 1'b0;
                    misp_q[e] <= 1'b0;
                end else if (clr_hit[e]) begin
                    busy_q[e] <= 1'b0;
                    dok_q[e]  <= 1'b0;
                    aok_q[e]  <= 1'b0;
                end else if (busy_q[e]) begin
                    if (res_valid && res_idx == IW'(e)) begin
                        data_q[e] <= res_data;
                        dok_q[e]  <= 1'b1;
                        misp_q[e] <= res_misp;
                    end
                    if (sta_valid && sta_idx == IW'(e)) begin
                        addr_q[e] <= sta_addr;
                        aok_q[e]  <= 1'b1;
                    end
                end
            end
        end
    end

    // Finished means result present, and for stores the address too.
    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            done_v[e] = busy_q[e] && dok_q[e] && (kind_q[e] != RQ_STORE || aok_q[e]);
            misp_v[e] = busy_q[e] && misp_q[e] && (kind_q[e] == RQ_BRANCH);
        end
    end

    // Read ports, one per retire lane.
    always_comb begin
        for (int i = 0; i < CW; i++) begin
            rd_kind[i] = kind_q[lane_idx[i]];
            rd_dest[i] = dest_q[lane_idx[i]];
            rd_data[i] = data_q[lane_idx[i]];
            rd_addr[i] = addr_q[lane_idx[i]];
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_chk
        // R3
        retire_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_hit[e] |-> (busy_q[e] && dok_q[e]));
        // R10
        claim_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_we && alloc_idx == IW'(e) && !flush) |=> (busy_q[e] && !dok_q[e] && !aok_q[e]));
        // R6
        store_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit[e] && kind_q[e] == RQ_STORE) |-> aok_q[e]);
    end
endmodule

// File: rtl/retire_queue.sv
// Module: top of the reorder buffer. Claims slots at issue, gathers tagged
// results and store addresses, and retires up to CW slots per cycle in
// program order as register or memory writes; a retiring mispredicted
// branch empties the queue.
// Assumes: the issue stage holds requests while alloc_ready is low; units
// discard work tagged for squashed slots when flush is seen.
module retire_queue
    import rq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 2,
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int RW    = 5,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1,
    localparam int NW   = $clog2(CW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [1:0]       alloc_kind,
    input  logic [RW-1:0]    alloc_dest,
    output logic             alloc_ready,
    output logic [IW-1:0]    alloc_tag,
    input  logic             res_valid,
    input  logic [IW-1:0]    res_tag,
    input  logic [DW-1:0]    res_data,
    input  logic             res_mispred,
    input  logic             sta_valid,
    input  logic [IW-1:0]    sta_tag,
    input  logic [AW-1:0]    sta_addr,
    output logic [CW-1:0]    rf_we,
    output logic [CW*RW-1:0] rf_idx,
    output logic [CW*DW-1:0] rf_data,
    output logic [CW-1:0]    mem_we,
    output logic [CW*AW-1:0] mem_addr,
    output logic [CW*DW-1:0] mem_data,
    output logic             flush
);
    logic [IW-1:0]          head_idx, tail_idx;
    logic [PW-1:0]          occ;
    logic                   full, empty, push;
    logic [CW-1:0][IW-1:0]  lane_idx;
    logic [CW-1:0]          lane_go;
    logic [NW-1:0]          n_go;
    logic [DEPTH-1:0]       done_v, misp_v;
    logic [CW-1:0][1:0]     rd_kind;
    logic [CW-1:0][RW-1:0]  rd_dest;
    logic [CW-1:0][DW-1:0]  rd_data;
    logic [CW-1:0][AW-1:0]  rd_addr;

    // Claim handshake; no claims in a flush cycle.
    assign alloc_ready = !full && !flush;
    assign alloc_tag   = tail_idx;
    assign push        = alloc_valid && alloc_ready;

    rq_ptrs #(.DEPTH(DEPTH), .CW(CW)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .push(push), .pop_n(n_go), .flush(flush),
        .head_idx(head_idx), .tail_idx(tail_idx), .occ(occ),
        .full(full), .empty(empty)
    );

    rq_commit_sel #(.DEPTH(DEPTH), .CW(CW)) u_sel (
        .head_idx(head_idx), .occ(occ), .done_v(done_v), .misp_v(misp_v),
        .lane_idx(lane_idx), .lane_go(lane_go), .n_go(n_go), .flush(flush)
    );

    rq_slots #(.DEPTH(DEPTH), .CW(CW), .DW(DW), .AW(AW), .RW(RW)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .alloc_we(push), .alloc_idx(tail_idx), .alloc_kind(rq_kind_e'(alloc_kind)),
        .alloc_dest(alloc_dest),
        .res_valid(res_valid), .res_idx(res_tag), .res_data(res_data), .res_misp(res_mispred),
        .sta_valid(sta_valid), .sta_idx(sta_tag), .sta_addr(sta_addr),
        .flush(flush), .lane_go(lane_go), .lane_idx(lane_idx),
        .done_v(done_v), .misp_v(misp_v),
        .rd_kind(rd_kind), .rd_dest(rd_dest), .rd_data(rd_data), .rd_addr(rd_addr)
    );

    // Steer each retiring lane to the register file or to memory.
    for (genvar i = 0; i < CW; i++) begin : g_lane
        assign rf_we[i]               = lane_go[i] && (rd_kind[i] == RQ_ALU);
        assign mem_we[i]              = lane_go[i] && (rd_kind[i] == RQ_STORE);
        assign rf_idx[i*RW +: RW]     = rd_dest[i];
        assign rf_data[i*DW +: DW]    = rd_data[i];
        assign mem_addr[i*AW +: AW]   = rd_addr[i];
        assign mem_data[i*DW +: DW]   = rd_data[i];
    end

    // R3
    quiet_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rf_we == '0 && mem_we == '0 && !flush));

    // R8
    reopen_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> alloc_ready);

    // R6
    lane_single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we & mem_we) == '0);
endmodule

// File: tb/tb_retire_queue.sv
module tb_retire_queue;
    localparam int DEPTH = 8, CW = 2, DW = 32, AW = 32, RW = 5, IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             alloc_valid = 0, res_valid = 0, res_mispred = 0, sta_valid = 0;
    logic [1:0]       alloc_kind = 0;
    logic [RW-1:0]    alloc_dest = 0;
    logic [IW-1:0]    res_tag = 0, sta_tag = 0;
    logic [DW-1:0]    res_data = 0;
    logic [AW-1:0]    sta_addr = 0;
    logic             alloc_ready, flush;
    logic [IW-1:0]    alloc_tag;
    logic [CW-1:0]    rf_we, mem_we;
    logic [CW*RW-1:0] rf_idx;
    logic [CW*DW-1:0] rf_data, mem_data;
    logic [CW*AW-1:0] mem_addr;

    retire_queue #(.DEPTH(DEPTH), .CW(CW), .DW(DW), .AW(AW), .RW(RW)) dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
        .alloc_dest(alloc_dest), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .res_mispred(res_mispred), .sta_valid(sta_valid), .sta_tag(sta_tag),
        .sta_addr(sta_addr), .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .flush(flush)
    );

    typedef struct {
        bit            st;
        logic [RW-1:0] idx;
        logic [DW-1:0] data;
        logic [AW-1:0] addr;
    } exp_t;
    exp_t q[$];

    int checks = 0, errors = 0, exp_tail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard for every write lane, oldest lane first.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int i = 0; i < CW; i++) begin
                if (rf_we[i] || mem_we[i]) begin
                    if (q.size() == 0) begin
                        chk(0, "R3", "write with nothing expected, lane", i, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(mem_we[i] == e.st, "R7", "lane is store", mem_we[i], e.st);
                        if (e.st) begin
                            chk(mem_addr[i*AW +: AW] == e.addr, "R6", "store address", mem_addr[i*AW +: AW], e.addr);
                            chk(mem_data[i*DW +: DW] == e.data, "R6", "store data", mem_data[i*DW +: DW], e.data);
                        end else begin
                            chk(rf_idx[i*RW +: RW] == e.idx, "R7", "dest register", rf_idx[i*RW +: RW], e.idx);
                            chk(rf_data[i*DW +: DW] == e.data, "R7", "register value", rf_data[i*DW +: DW], e.data);
                        end
                    end
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic alloc(input logic [1:0] k, input logic [RW-1:0] d, output logic [IW-1:0] t);
        alloc_valid = 1; alloc_kind = k; alloc_dest = d;
        #1;
        chk(alloc_ready, "R2", "slot available", alloc_ready, 1);
        chk(alloc_tag == IW'(exp_tail), "R2", "claimed tag", alloc_tag, exp_tail);
        t = alloc_tag;
        tick();
        alloc_valid = 0;
        exp_tail = (exp_tail + 1) % DEPTH;
    endtask

    task automatic result(input logic [IW-1:0] t, input logic [DW-1:0] v, input logic m);
        res_valid = 1; res_tag = t; res_data = v; res_mispred = m;
        tick();
        res_valid = 0; res_mispred = 0;
    endtask

    task automatic staddr(input logic [IW-1:0] t, input logic [AW-1:0] a);
        sta_valid = 1; sta_tag = t; sta_addr = a;
        tick();
        sta_valid = 0;
    endtask

    task automatic exp_reg(input logic [RW-1:0] d, input logic [DW-1:0] v);
        q.push_back('{st: 1'b0, idx: d, data: v, addr: '0});
    endtask

    task automatic exp_store(input logic [AW-1:0] a, input logic [DW-1:0] v);
        q.push_back('{st: 1'b1, idx: '0, data: v, addr: a});
    endtask

    task automatic summary();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R4 watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        logic [IW-1:0] ta, tb, tc, ts, tx, tbr, ty, tz, tw, tp, t1;
        logic [IW-1:0] tg [DEPTH];
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        #1;
        chk(alloc_ready == 1, "R1", "ready after reset", alloc_ready, 1);
        chk(alloc_tag == 0, "R1", "first tag", alloc_tag, 0);
        chk(rf_we == 0 && mem_we == 0, "R1", "no writes", {rf_we, mem_we}, 0);
        chk(flush == 0, "R1", "no flush", flush, 0);

        // R3 R4: results arrive youngest first
        alloc(0, 5'd1, ta); exp_reg(5'd1, 32'hA1);
        alloc(0, 5'd2, tb); exp_reg(5'd2, 32'hB2);
        alloc(0, 5'd3, tc); exp_reg(5'd3, 32'hC3);
        result(tc, 32'hC3, 0);
        result(tb, 32'hB2, 0);
        @(negedge clk);
        chk(rf_we == 0, "R3", "younger finished slots wait", rf_we, 0);
        tick();
        result(ta, 32'hA1, 0);
        @(negedge clk);
        chk(rf_we == 2'b11, "R4", "two lanes retire", rf_we, 2'b11);
        tick();
        @(negedge clk);
        chk(rf_we == 2'b01, "R4", "remaining slot retires", rf_we, 2'b01);
        tick();

        // R6 store: data then address
        alloc(1, 5'd0, ts); exp_store(32'h4000, 32'h5151);
        result(ts, 32'h5151, 0);
        @(negedge clk);
        chk(mem_we == 0, "R6", "store waits for address", mem_we, 0);
        tick();
        staddr(ts, 32'h4000);
        @(negedge clk);
        chk(mem_we == 2'b01 && rf_we == 0, "R6", "store writes memory only", {rf_we, mem_we}, 2'b01);
        tick();

        // R6 store: address then data
        alloc(1, 5'd0, ts); exp_store(32'h4444, 32'h6262);
        staddr(ts, 32'h4444);
        @(negedge clk);
        chk(mem_we == 0, "R6", "store waits for data", mem_we, 0);
        tick();
        result(ts, 32'h6262, 0);
        @(negedge clk);
        chk(mem_we == 2'b01, "R6", "store retires", mem_we, 2'b01);
        tick();

        // R5 full queue, wrapped indices, ignored extra request
        for (int k = 0; k < DEPTH; k++) begin
            alloc(0, RW'(k + 8), tg[k]);
            exp_reg(RW'(k + 8), 32'h1000 + k);
        end
        chk(alloc_ready == 0, "R5", "ready when full", alloc_ready, 0);
        alloc_valid = 1; alloc_kind = 0; alloc_dest = 5'd31;
        tick();
        alloc_valid = 0;
        for (int k = DEPTH - 1; k >= 0; k--) result(tg[k], 32'h1000 + k, 0);
        repeat (6) tick();
        chk(alloc_ready == 1, "R5", "ready after drain", alloc_ready, 1);
        chk(alloc_tag == IW'(exp_tail), "R5", "blocked request claimed nothing", alloc_tag, exp_tail);
        chk(q.size() == 0, "R4", "all full-queue slots retired", q.size(), 0);

        // R8 mispredicted branch retires in the same cycle as an older slot
        alloc(0, 5'd3, tx); exp_reg(5'd3, 32'hAAAA);
        alloc(2, 5'd0, tbr);
        alloc(0, 5'd4, ty);
        alloc(0, 5'd5, tz);
        result(ty, 32'hDEAD, 0);
        result(tz, 32'hBEEF, 0);
        result(tbr, 32'h0, 1);
        @(negedge clk);
        chk(flush == 0, "R8", "branch behind unfinished slot", flush, 0);
        tick();
        result(tx, 32'hAAAA, 0);
        @(negedge clk);
        chk(flush == 1, "R8", "flush on retire", flush, 1);
        chk(rf_we == 2'b01, "R8", "only older slot writes", rf_we, 2'b01);
        tick();
        exp_tail = (int'(tbr) + 1) % DEPTH;
        chk(alloc_tag == IW'(exp_tail), "R8", "next tag after flush", alloc_tag, exp_tail);
        chk(alloc_ready == 1, "R8", "queue empty after flush", alloc_ready, 1);

        // R9 R10 stale results to squashed slots
        result(ty, 32'h0BAD, 0);
        result(tz, 32'h0BAD, 0);
        @(negedge clk);
        chk(rf_we == 0 && mem_we == 0, "R9", "stale result ignored", {rf_we, mem_we}, 0);
        tick();
        alloc(0, 5'd6, tw); exp_reg(5'd6, 32'h77);
        chk(tw == ty, "R10", "slot reused", tw, ty);
        tick();
        @(negedge clk);
        chk(rf_we == 0, "R10", "reused slot waits for its own result", rf_we, 0);
        tick();
        result(tw, 32'h77, 0);
        repeat (2) tick();

        // R8 correctly predicted branch retires silently
        alloc(2, 5'd0, t1);
        alloc(0, 5'd7, tp); exp_reg(5'd7, 32'h55);
        result(tp, 32'h55, 0);
        result(t1, 32'h0, 0);
        @(negedge clk);
        chk(flush == 0, "R8", "no flush for correct branch", flush, 0);
        chk(rf_we == 2'b10, "R8", "branch lane silent", rf_we, 2'b10);
        tick();

        // R2 long stream wrapping the indices several times
        for (int k = 0; k < 20; k++) begin
            alloc(0, RW'(k), t1);
            exp_reg(RW'(k), 32'h2000 + k);
            result(t1, 32'h2000 + k, 0);
        end
        repeat (4) tick();
        chk(q.size() == 0, "R3", "scoreboard drained", q.size(), 0);
        summary();
    end
endmodule